// File: doc/BRIEF.md
# Modulo Up/Down Counter with Prioritised Synchronous Controls

This block is a synchronous binary counter whose width is a build parameter. It can wrap at a programmable modulus, or at the natural power-of-two boundary when the modulus is off. The counting direction is fixed at build time as up or down, or it is taken each cycle from a direction input.

Besides counting, the register can be cleared to zero, forced to a constant set value, or loaded from a data input. All of these are synchronous. Two enables gate the block. The clock enable freezes the whole register. The count enable stops only the counting step, so clear, set and load still act while it is low. The single output is the current count. In a signed reading of the count, the top bit is the sign bit. A split of the word into integer and fraction bits is only a reading of the output and does not change any behaviour.

All pins are plain control and data pins. No word stream passes through the block, so there is no handshake and no back-pressure.

Top module: `modwrap_counter`

## Requirements
- R1: While `rst` is high on a rising clock edge, the count becomes 0.
- R2: With `clk_en` low, the count keeps its value whatever `sclr`, `sset`, `sload`, `cnt_en` and `up_dn` do.
- R3: With `clk_en` high and `sclr` high, the count becomes 0, overriding set, load and count.
- R4: With `clk_en` high, `sclr` low and `sset` high (and HAS_SET=1), the count becomes SET_VALUE, overriding load and count.
- R5: With `clk_en` high, `sclr` and `sset` inactive and `sload` high, the count takes `load_data`, overriding the count step.
- R6: With `clk_en` high, no clear, set or load, and `cnt_en` low, the count holds.
- R7: With USE_MOD=1, an up step from MODULUS-1 gives 0; below that, an up step adds one.
- R8: With USE_MOD=1, a down step from 0 gives MODULUS-1; otherwise a down step subtracts one.
- R9: With USE_MOD=1, a loaded value at or above MODULUS is kept. The next up step then gives 0.
- R10: With DIR_MODE=DIR_PORT, `up_dn`=1 counts up and `up_dn`=0 counts down.
- R11: With USE_MOD=0, the count wraps at 2^WIDTH: a down step from 0 gives all ones, and an up step from all ones gives 0.
- R12: With DIR_MODE fixed to DIR_DOWN or DIR_UP, `up_dn` has no effect on the direction.
- R13: With HAS_SET=0, `sset` is ignored, and the other controls behave as if it were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; low freezes the register |
| cnt_en | input | 1 | Count enable; low stops only the counting step |
| sclr | input | 1 | Synchronous clear to zero |
| sset | input | 1 | Synchronous set to SET_VALUE |
| sload | input | 1 | Synchronous load strobe |
| load_data | input | WIDTH | Value taken when `sload` acts |
| up_dn | input | 1 | Runtime direction, 1 = up, 0 = down (DIR_PORT mode only) |
| count | output | WIDTH | Current count value |

## Verification
The interesting collisions are between controls asserted in the same cycle: clear, set, load and a count step all at once, and an active control while `clk_en` is low. The bench asserts every lower-priority control together with the one under test. It then checks that the resulting count matches only the highest-priority action, or matches the old value when the clock enable is low. A second collision, the count step landing on a value that a load has just pushed past the modulus, is provoked by loading an out-of-range value and then counting once. The result is judged against the wrap-to-zero rule.

// File: rtl/modwrap_pkg.sv
package modwrap_pkg;

  typedef enum logic [1:0] {
    DIR_UP   = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_PORT = 2'd2
  } dir_mode_e;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_SET   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STEP  = 3'd4
  } op_e;

endpackage

// File: rtl/modwrap_arbiter.sv
module modwrap_arbiter
  import modwrap_pkg::*;
#(
  parameter int HAS_SET = 1
) (
  input  logic clk_en,
  input  logic cnt_en,
  input  logic sclr,
  input  logic sset,
  input  logic sload,
  output op_e  op
);

  logic set_live;
  assign set_live = sset && (HAS_SET != 0);

  always_comb begin
    if (!clk_en)        op = OP_HOLD;
    else if (sclr)      op = OP_CLEAR;
    else if (set_live)  op = OP_SET;
    else if (sload)     op = OP_LOAD;
    else if (cnt_en)    op = OP_STEP;
    else                op = OP_HOLD;
  end

endmodule

// File: rtl/modwrap_stepper.sv
module modwrap_stepper
  import modwrap_pkg::*;
#(
  parameter int        WIDTH    = 8,
  parameter int        USE_MOD  = 1,
  parameter int        MODULUS  = 10,
  parameter dir_mode_e DIR_MODE = DIR_PORT
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             up_dn,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] TOP_VAL =
    (USE_MOD != 0) ? WIDTH'(MODULUS - 1) : {WIDTH{1'b1}};

  logic go_up;
  assign go_up = (DIR_MODE == DIR_PORT) ? up_dn : (DIR_MODE == DIR_UP);

  always_comb begin
    if (go_up) nxt = (cur >= TOP_VAL) ? '0 : cur + 1'b1;
    else       nxt = (cur == '0) ? TOP_VAL : cur - 1'b1;
  end

endmodule

// File: rtl/modwrap_counter.sv
module modwrap_counter
  import modwrap_pkg::*;
#(
  parameter int        WIDTH     = 8,
  parameter int        USE_MOD   = 1,
  parameter int        MODULUS   = 10,
  parameter int        HAS_SET   = 1,
  parameter int        SET_VALUE = 7,
  parameter dir_mode_e DIR_MODE  = DIR_PORT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             cnt_en,
  input  logic             sclr,
  input  logic             sset,
  input  logic             sload,
  input  logic [WIDTH-1:0] load_data,
  input  logic             up_dn,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] SET_WORD = WIDTH'(SET_VALUE);
  localparam logic [WIDTH-1:0] TOP_VAL  =
    (USE_MOD != 0) ? WIDTH'(MODULUS - 1) : {WIDTH{1'b1}};

  if (USE_MOD != 0 && WIDTH > 31) begin : g_bad_mod
    $error("modulus option needs WIDTH of 31 or less");
  end
  if (HAS_SET != 0 && WIDTH > 31) begin : g_bad_set
    $error("set option needs WIDTH of 31 or less");
  end
  if (HAS_SET != 0 && USE_MOD != 0 && SET_VALUE >= MODULUS) begin : g_bad_setval
    $error("SET_VALUE must lie below MODULUS");
  end

  op_e              op;
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] next_q;

  modwrap_arbiter #(.HAS_SET(HAS_SET)) u_arb (
    .clk_en (clk_en),
    .cnt_en (cnt_en),
    .sclr   (sclr),
    .sset   (sset),
    .sload  (sload),
    .op     (op)
  );

  modwrap_stepper #(
    .WIDTH    (WIDTH),
    .USE_MOD  (USE_MOD),
    .MODULUS  (MODULUS),
    .DIR_MODE (DIR_MODE)
  ) u_step (
    .cur   (count),
    .up_dn (up_dn),
    .nxt   (stepped)
  );

  always_comb begin
    unique case (op)
      OP_CLEAR: next_q = '0;
      OP_SET:   next_q = SET_WORD;
      OP_LOAD:  next_q = load_data;
      OP_STEP:  next_q = stepped;
      default:  next_q = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= next_q;
  end

  p_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> count == $past(count));

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sclr) |=> count == '0);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (HAS_SET != 0 && clk_en && !sclr && sset) |=> count == SET_WORD);

  p_load_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sclr && !(sset && HAS_SET != 0) && sload)
    |=> count == $past(load_data));

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sclr && !(sset && HAS_SET != 0) && !sload && !cnt_en)
    |=> $stable(count));

  p_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sclr && !(sset && HAS_SET != 0) && !sload && cnt_en &&
     count <= TOP_VAL) |=> count <= TOP_VAL);

endmodule

// File: tb/sim_modwrap_counter.sv
module sim_modwrap_counter;
  import modwrap_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b0, cnt_en = 1'b0, sclr = 1'b0, sset = 1'b0, sload = 1'b0;
  logic [7:0] load_data = 8'd0;
  logic       up_dn = 1'b1;
  logic [7:0] count, count_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  modwrap_counter #(.WIDTH(8), .USE_MOD(1), .MODULUS(10), .HAS_SET(1),
                    .SET_VALUE(7), .DIR_MODE(DIR_PORT)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cnt_en(cnt_en), .sclr(sclr),
    .sset(sset), .sload(sload), .load_data(load_data), .up_dn(up_dn),
    .count(count));

  modwrap_counter #(.WIDTH(8), .USE_MOD(0), .MODULUS(10), .HAS_SET(0),
                    .SET_VALUE(3), .DIR_MODE(DIR_DOWN)) u1 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cnt_en(cnt_en), .sclr(sclr),
    .sset(sset), .sload(sload), .load_data(load_data), .up_dn(up_dn),
    .count(count_b));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    clk_en = 1'b1; cnt_en = 1'b0; sclr = 1'b0; sset = 1'b0; sload = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick();
    check("R1 reset", count, 8'd0);
    rst = 1'b0; quiet();
  endtask

  task automatic t_up_wrap();
    sload = 1'b1; load_data = 8'd8; tick();
    check("R5 load 8", count, 8'd8);
    sload = 1'b0; cnt_en = 1'b1; up_dn = 1'b1; tick();
    check("R7 up to 9", count, 8'd9);
    tick();
    check("R7 wrap 9->0", count, 8'd0);
    quiet();
  endtask

  task automatic t_down_wrap();
    cnt_en = 1'b1; up_dn = 1'b0; tick();
    check("R8 wrap 0->9", count, 8'd9);
    tick();
    check("R8 down to 8", count, 8'd8);
    up_dn = 1'b1; tick();
    check("R10 port up", count, 8'd9);
    quiet();
  endtask

  task automatic t_clear_priority();
    sclr = 1'b1; sset = 1'b1; sload = 1'b1; load_data = 8'd4; cnt_en = 1'b1; tick();
    check("R3 clear wins", count, 8'd0);
    quiet();
  endtask

  task automatic t_set_priority();
    sset = 1'b1; sload = 1'b1; load_data = 8'd4; cnt_en = 1'b1; tick();
    check("R4 set wins", count, 8'd7);
    quiet();
  endtask

  task automatic t_load_priority();
    sload = 1'b1; load_data = 8'd5; cnt_en = 1'b1; tick();
    check("R5 load beats step", count, 8'd5);
    quiet();
  endtask

  task automatic t_count_enable();
    cnt_en = 1'b0; up_dn = 1'b1; tick(); tick();
    check("R6 count enable low", count, 8'd5);
    quiet();
  endtask

  task automatic t_clock_enable();
    clk_en = 1'b0; sclr = 1'b1; sset = 1'b1; sload = 1'b1; load_data = 8'd2;
    cnt_en = 1'b1; tick(); tick();
    check("R2 clock enable low", count, 8'd5);
    quiet();
  endtask

  task automatic t_over_modulus();
    sload = 1'b1; load_data = 8'd200; tick();
    check("R9 keep loaded 200", count, 8'd200);
    sload = 1'b0; cnt_en = 1'b1; up_dn = 1'b1; tick();
    check("R9 step from 200", count, 8'd0);
    quiet();
  endtask

  task automatic t_fixed_natural();
    rst = 1'b1; tick(); rst = 1'b0; quiet();
    cnt_en = 1'b1; up_dn = 1'b1; tick();
    check("R11 R12 fixed down wraps", count_b, 8'd255);
    sset = 1'b1; tick();
    check("R13 set ignored", count_b, 8'd254);
    quiet();
  endtask

  initial begin
    t_reset();
    t_up_wrap();
    t_down_wrap();
    t_clear_priority();
    t_set_priority();
    t_load_priority();
    t_count_enable();
    t_clock_enable();
    t_over_modulus();
    t_fixed_natural();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule